// File: doc/BRIEF.md
# Reset Control Port

This block is one byte-wide I/O register that software uses to ask for a system reset and to choose which kind of reset it wants. It sits on a plain I/O bus that presents a dword-aligned address, four byte enables, write data, and read and write strobes. The register occupies byte lane 1 of the dword at 0xCF8, so a single-byte access to port 0xCF9 reaches it.

A write that carries the trigger bit raises a reset request for exactly one clock and leaves the stored value as it was. Every other write to the register keeps only the reset-kind bit and clears everything else. A read returns the stored byte one cycle later, on lane 1 of the read data, together with a one-cycle valid flag. The sequencer that acts on the reset request is outside this block.

Top module: `rcr_ctrl`

## Requirements
- R1: After reset, the stored byte is 0x00, `sys_rst_req` is low and `io_rdata_vld` is low.
- R2: A write that hits the register with write-data bit 10 set (bit 2 of lane 1, the trigger) drives `sys_rst_req` high for exactly the one cycle after the write edge.
- R3: A triggering write leaves the stored byte unchanged.
- R4: A hitting write with the trigger bit clear stores data bit 9 (bit 1 of lane 1, the reset kind) and clears every other bit, so the stored byte is always 0x00 or 0x02.
- R5: A hitting read sets `io_rdata_vld` for the next cycle with the stored byte on `io_rdata[15:8]` and zero in every other bit. A read and a write in the same cycle return the value from before the write.
- R6: An access hits only when `io_addr[15:2]` equals 0xCF8>>2 and `io_addr[1:0]` is zero. Any other address neither changes the register nor raises the request, and a read to it leaves `io_rdata_vld` low and `io_rdata` zero.
- R7: An access with `io_be[1]` low is ignored in the same way, whatever the other byte enables are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Dword-aligned I/O address |
| io_be | input | 4 | Byte enables, one per lane |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 32 | Write data |
| io_rdata | output | 32 | Read data, non-zero only while valid |
| io_rdata_vld | output | 1 | Read data valid, one cycle after a hitting read |
| sys_rst_req | output | 1 | One-cycle system reset request |

## Verification
The state is a single bit, and it is visible only through a read. A wrong stored value therefore appears on `io_rdata[15:8]` one cycle after the next hitting read, and never before. A fault in decode or in the trigger path shows on `sys_rst_req` in the cycle after the offending write. The bench reads the register back after every kind of write, including triggering writes, misses and masked lanes, so a stray update is caught at the first read that follows it.

// File: rtl/rcr_pkg.sv
package rcr_pkg;
  // Bit positions inside the register byte; software depends on them.
  localparam int unsigned KIND_BIT = 1;
  localparam int unsigned TRIG_BIT = 2;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/rcr_decode.sv
module rcr_decode #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 4,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic [ADDR_W-1:0]    io_addr,
  input  logic [BUS_BYTES-1:0] io_be,
  input  logic                 io_wr,
  input  logic                 io_rd,
  output logic                 wr_hit,
  output logic                 rd_hit
);
  localparam int unsigned LANE_W = $clog2(BUS_BYTES);
  localparam int unsigned LANE   = PORT_ADDR % BUS_BYTES;

  logic sel;

  // Aligned dword must match and the register's lane must be enabled.
  always_comb begin
    sel = (io_addr[ADDR_W-1:LANE_W] == PORT_ADDR[ADDR_W-1:LANE_W])
        && (io_addr[LANE_W-1:0] == '0)
        && io_be[LANE];
    wr_hit = sel && io_wr;
    rd_hit = sel && io_rd;
  end
endmodule

// File: rtl/rcr_store.sv
module rcr_store
  import rcr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_hit,
  input  logic [BYTE_W-1:0] wbyte,
  output logic [BYTE_W-1:0] stored,
  output logic              req_pulse
);
  logic kind_q;
  logic trig;
  logic unused_wbits;

  assign trig = wbyte[TRIG_BIT];
  assign unused_wbits = ^{wbyte[BYTE_W-1:TRIG_BIT+1], wbyte[KIND_BIT-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q    <= 1'b0;
      req_pulse <= 1'b0;
    end else begin
      req_pulse <= wr_hit && trig;
      if (wr_hit && !trig) kind_q <= wbyte[KIND_BIT];
    end
  end

  always_comb begin
    stored = '0;
    stored[KIND_BIT] = kind_q;
  end
endmodule

// File: rtl/rcr_rdpath.sv
module rcr_rdpath
  import rcr_pkg::*;
#(
  parameter int unsigned BUS_BYTES = 4,
  parameter int unsigned LANE      = 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          rd_hit,
  input  logic [BYTE_W-1:0]             stored,
  output logic [BUS_BYTES*BYTE_W-1:0]   rdata,
  output logic                          rdata_vld
);
  logic [BUS_BYTES*BYTE_W-1:0] placed;

  always_comb begin
    placed = '0;
    placed[LANE*BYTE_W +: BYTE_W] = stored;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata     <= '0;
      rdata_vld <= 1'b0;
    end else begin
      rdata_vld <= rd_hit;
      rdata     <= rd_hit ? placed : '0;
    end
  end
endmodule

// File: rtl/rcr_ctrl.sv
module rcr_ctrl
  import rcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 4,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [ADDR_W-1:0]           io_addr,
  input  logic [BUS_BYTES-1:0]        io_be,
  input  logic                        io_wr,
  input  logic                        io_rd,
  input  logic [BUS_BYTES*BYTE_W-1:0] io_wdata,
  output logic [BUS_BYTES*BYTE_W-1:0] io_rdata,
  output logic                        io_rdata_vld,
  output logic                        sys_rst_req
);
  localparam int unsigned LANE = PORT_ADDR % BUS_BYTES;

  logic              wr_hit;
  logic              rd_hit;
  logic [BYTE_W-1:0] stored;
  logic [BYTE_W-1:0] wbyte;

  assign wbyte = io_wdata[LANE*BYTE_W +: BYTE_W];

  rcr_decode #(
    .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .PORT_ADDR(PORT_ADDR)
  ) u_dec (
    .io_addr(io_addr), .io_be(io_be), .io_wr(io_wr), .io_rd(io_rd),
    .wr_hit(wr_hit), .rd_hit(rd_hit)
  );

  rcr_store u_store (
    .clk(clk), .rst_n(rst_n), .wr_hit(wr_hit), .wbyte(wbyte),
    .stored(stored), .req_pulse(sys_rst_req)
  );

  rcr_rdpath #(.BUS_BYTES(BUS_BYTES), .LANE(LANE)) u_rd (
    .clk(clk), .rst_n(rst_n), .rd_hit(rd_hit), .stored(stored),
    .rdata(io_rdata), .rdata_vld(io_rdata_vld)
  );
endmodule

// File: rtl/rcr_ctrl_chk.sv
module rcr_ctrl_chk
  import rcr_pkg::*;
#(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned BUS_BYTES = 4,
  parameter logic [ADDR_W-1:0] PORT_ADDR = 16'hCF9
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [ADDR_W-1:0]           io_addr,
  input logic [BUS_BYTES-1:0]        io_be,
  input logic                        io_wr,
  input logic                        io_rd,
  input logic [BUS_BYTES*BYTE_W-1:0] io_wdata,
  input logic [BUS_BYTES*BYTE_W-1:0] io_rdata,
  input logic                        io_rdata_vld,
  input logic                        sys_rst_req
);
  localparam int unsigned LANE   = PORT_ADDR % BUS_BYTES;
  localparam int unsigned LANE_W = $clog2(BUS_BYTES);
  localparam logic [BUS_BYTES*BYTE_W-1:0] KIND_WORD =
    (BUS_BYTES*BYTE_W)'(1) << (LANE*BYTE_W + KIND_BIT);

  logic sel_c;
  logic trig_wr_c;
  assign sel_c = (io_addr[ADDR_W-1:LANE_W] == PORT_ADDR[ADDR_W-1:LANE_W])
               && (io_addr[LANE_W-1:0] == '0) && io_be[LANE];
  assign trig_wr_c = sel_c && io_wr && io_wdata[LANE*BYTE_W + TRIG_BIT];

  assert_req_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_req |-> $past(trig_wr_c));

  assert_req_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
    trig_wr_c |=> sys_rst_req);

  assert_read_form_R4: assert property (@(posedge clk) disable iff (!rst_n)
    io_rdata_vld |-> (io_rdata == '0 || io_rdata == KIND_WORD));

  assert_read_valid_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_c && io_rd) |=> io_rdata_vld);

  assert_miss_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !(sel_c && io_rd) |=> (!io_rdata_vld && io_rdata == '0));
endmodule

bind rcr_ctrl rcr_ctrl_chk #(
  .ADDR_W(ADDR_W), .BUS_BYTES(BUS_BYTES), .PORT_ADDR(PORT_ADDR)
) u_chk (.*);

// File: tb/tb_rcr_ctrl.sv
module tb_rcr_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic [3:0]  io_be = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [31:0] io_wdata = '0;
  logic [31:0] io_rdata;
  logic        io_rdata_vld;
  logic        sys_rst_req;

  int checks = 0;
  int fails = 0;
  logic [7:0] exp_reg = 8'h00;
  logic done = 1'b0;

  always #2.5 clk = ~clk;

  rcr_ctrl dut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One-cycle write; returns request level in the following cycle and the one after.
  task automatic do_write(input logic [15:0] a, input logic [3:0] be, input logic [31:0] d,
                          output logic req1, output logic req2);
    @(negedge clk);
    io_addr = a; io_be = be; io_wdata = d; io_wr = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_be = '0;
    req1 = sys_rst_req;
    @(negedge clk);
    req2 = sys_rst_req;
  endtask

  task automatic do_read(input logic [15:0] a, input logic [3:0] be,
                         output logic [31:0] d, output logic v);
    @(negedge clk);
    io_addr = a; io_be = be; io_rd = 1'b1;
    @(negedge clk);
    io_rd = 1'b0; io_be = '0;
    d = io_rdata; v = io_rdata_vld;
  endtask

  task automatic readback(input string req);
    logic [31:0] d; logic v;
    do_read(16'hCF8, 4'b0010, d, v);
    chk(req, {31'b0, v}, 32'd1);
    chk(req, d, {16'h0, exp_reg, 8'h00});
  endtask

  task automatic t_reset;
    chk("R1 req", {31'b0, sys_rst_req}, 0);
    chk("R1 vld", {31'b0, io_rdata_vld}, 0);
    readback("R1 value");
  endtask

  task automatic t_store_kind;
    logic r1, r2;
    do_write(16'hCF8, 4'b0010, 32'h0000_FB00, r1, r2); // all bits but trigger
    exp_reg = 8'h02;
    chk("R4 no req", {30'b0, r1, r2}, 0);
    readback("R4 keep kind only");
    do_write(16'hCF8, 4'b1111, 32'hFFFF_F9FF, r1, r2); // kind clear
    exp_reg = 8'h00;
    readback("R4 clear kind");
    do_write(16'hCF8, 4'b0010, 32'h0000_0200, r1, r2);
    exp_reg = 8'h02;
    readback("R4 set again");
  endtask

  task automatic t_trigger;
    logic r1, r2;
    do_write(16'hCF8, 4'b0010, 32'h0000_0400, r1, r2); // kind clear + trigger
    chk("R2 pulse", {31'b0, r1}, 1);
    chk("R2 one cycle", {31'b0, r2}, 0);
    readback("R3 unchanged after trigger");
    do_write(16'hCF8, 4'b0010, 32'h0000_0600, r1, r2);
    chk("R2 pulse kind set", {30'b0, r1, r2}, 2);
    readback("R3 unchanged again");
  endtask

  task automatic t_miss;
    logic r1, r2; logic [31:0] d; logic v;
    do_write(16'hCFC, 4'b0010, 32'h0000_0400, r1, r2);
    chk("R6 other dword no req", {30'b0, r1, r2}, 0);
    do_write(16'hCF9, 4'b0010, 32'h0000_0000, r1, r2); // unaligned address
    readback("R6 unaligned no store");
    do_read(16'hCF4, 4'b0010, d, v);
    chk("R6 read miss vld", {31'b0, v}, 0);
    chk("R6 read miss data", d, 0);
  endtask

  task automatic t_lane;
    logic r1, r2; logic [31:0] d; logic v;
    do_write(16'hCF8, 4'b1101, 32'h0000_0400, r1, r2);
    chk("R7 masked no req", {30'b0, r1, r2}, 0);
    do_write(16'hCF8, 4'b1101, 32'h0000_0000, r1, r2);
    readback("R7 masked no store");
    do_read(16'hCF8, 4'b0001, d, v);
    chk("R7 masked read vld", {31'b0, v}, 0);
    chk("R7 masked read data", d, 0);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    @(negedge clk);
    io_addr = 16'hCF8; io_be = 4'b0010; io_wdata = 32'h0; io_wr = 1'b1; io_rd = 1'b1;
    @(negedge clk);
    io_wr = 1'b0; io_rd = 1'b0; io_be = '0;
    d = io_rdata;
    chk("R5 old value on collision", d, {16'h0, exp_reg, 8'h00});
    exp_reg = 8'h00;
    readback("R5 new value after");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_store_kind();
    t_trigger();
    t_miss();
    t_lane();
    t_same_cycle();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule